// File: doc/BRIEF.md
# Programmable Index and Sector Mark Generator

This block produces soft-sectored timing pulses for a rotating-media drive. It takes two strobes from the clock-track read path. The first is a once-per-revolution index reference. The second is a byte-rate tick. From these it forms an index pulse, a sector-mark pulse, a byte-clock pulse, one shared output line that carries either sector marks or byte clocks, and the number of the current sector. A fixed number of byte times makes up one track (default 12,000).

A 12-bit bytes-per-sector value comes in on configuration inputs. The block copies it into a working register only when an index reference arrives, so a single revolution never mixes two settings. The track length is usually not a whole multiple of the sector length. In that case the final sector keeps counting past its nominal length and absorbs the leftover bytes. A setting of zero turns sector marks off. A configuration bit chooses whether a sector mark is also issued together with index. Pulse widths are counted in system clocks: 1.7 µs for index and sector marks, 0.84 µs for byte clocks.

The counter is a small state machine with three states. TS_SEEK_INDEX is the reset state: no index has been seen, so nothing is counted. TS_COUNT counts the bytes of the current revolution. TS_TRACK_END is entered once the full track length has been counted, and it waits for the next index. Four transitions connect them:
- An index reference in any state leads to TS_COUNT.
- In TS_COUNT, the byte that completes the track leads to TS_TRACK_END.
- TS_SEEK_INDEX holds until an index reference arrives.
- TS_TRACK_END holds until an index reference arrives.

Top module: `sector_mark_gen`

## Requirements
- R1: After reset, every pulse output is low and `sector_num` is 0.
- R2: An index reference sampled at edge E causes `index_pulse` to rise after edge E+1. The pulse stays high for MARK_W clocks, where MARK_W = max(1, floor(CLK_PER_US*17/10)). Every sector mark has the same width.
- R3: Each byte tick produces one `byteclk_pulse` of BYTE_W clocks, where BYTE_W = max(1, floor(CLK_PER_US*84/100)). This happens whether or not an index has been seen.
- R4: An index reference sets `sector_num` to 0. After that, a sector mark is issued and `sector_num` goes up by one each time another bytes-per-sector bytes have been counted.
- R5: No boundary is made when fewer than bytes-per-sector bytes remain in the track. The last sector therefore takes the remainder, and one revolution gives floor(TRACK_BYTES/bps) sectors and floor(TRACK_BYTES/bps)-1 in-track marks. A value of bps larger than the track gives no in-track marks.
- R6: When `cfg_mark_at_index` is 1 and the bytes-per-sector value being loaded is non-zero, a sector mark is issued together with the index pulse. When `cfg_mark_at_index` is 0, no mark is issued at index.
- R7: `shared_out` carries `byteclk_pulse` when `cfg_sel_byteclk` is 1, and `sector_pulse` when it is 0.
- R8: A change of `cfg_bps` in mid-revolution has no effect until the next index reference.
- R9: A bytes-per-sector value of 0 suppresses every sector mark, including the one at index, and `sector_num` stays 0.
- R10: Byte ticks produce no sector marks before the first index, or after the whole track has been counted and before the next index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_ref | input | 1 | One-cycle strobe, once per revolution |
| byte_tick | input | 1 | One-cycle strobe per byte time |
| cfg_bps | input | BPS_W | Bytes per sector (0 = no marks) |
| cfg_sel_byteclk | input | 1 | 1: shared_out carries byte clocks; 0: sector marks |
| cfg_mark_at_index | input | 1 | 1: also issue a sector mark at index |
| index_pulse | output | 1 | Shaped index pulse |
| sector_pulse | output | 1 | Shaped sector-mark pulse |
| byteclk_pulse | output | 1 | Shaped byte-clock pulse |
| shared_out | output | 1 | Selected pulse line |
| sector_num | output | SEC_W | Current sector, 0 after index |

## Verification
The bench runs full revolutions with several sector lengths: one that divides the track exactly, one that leaves a remainder, a very short one, one longer than the track, and zero. Comparing the mark count with floor(track/bps)-1 shows whether the remainder is folded into the last sector or produces an extra short sector. A mid-revolution setting change followed by a second revolution tells a deferred load apart from an immediate one. Byte runs before the first index and past the track end show whether the counter is gated by its state. The shared line is counted under both select values.

// File: rtl/smg_pkg.sv
package smg_pkg;
    typedef enum logic [1:0] {
        TS_SEEK_INDEX = 2'd0,
        TS_COUNT      = 2'd1,
        TS_TRACK_END  = 2'd2
    } trk_state_t;

    // clocks for a width given in hundredths of a microsecond, at least 1
    function automatic int width_clks(input int clk_per_us, input int centi_us);
        int w;
        w = (clk_per_us * centi_us) / 100;
        return (w < 1) ? 1 : w;
    endfunction
endpackage

// File: rtl/smg_pulse_shaper.sv
module smg_pulse_shaper #(
    parameter int W_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int CW = $clog2(W_CLKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (trig)
            cnt <= CW'(W_CLKS);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign pulse = (cnt != '0);

    p_trig_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pulse);
    p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(trig));
endmodule

// File: rtl/smg_sector_counter.sv
module smg_sector_counter
    import smg_pkg::*;
#(
    parameter int TRACK_BYTES = 12000,
    parameter int BPS_W       = 12,
    parameter int SEC_W       = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_ref,
    input  logic             byte_tick,
    input  logic [BPS_W-1:0] cfg_bps,
    input  logic             cfg_mark_at_index,
    output logic             idx_evt,
    output logic             sec_evt,
    output logic             byte_evt,
    output logic [SEC_W-1:0] sec_num
);
    localparam int POS_W = $clog2(TRACK_BYTES + 1);
    localparam int CW    = ((POS_W > BPS_W) ? POS_W : BPS_W) + 1;
    localparam logic [CW-1:0] TRACK_C = CW'(TRACK_BYTES);

    trk_state_t       state, state_nx;
    logic [CW-1:0]    byte_pos, sec_bytes, bps_c, nxt_pos, remain;
    logic [BPS_W-1:0] bps_act;
    logic             boundary, last_byte;

    assign bps_c     = CW'(bps_act);
    assign nxt_pos   = byte_pos + 1'b1;
    assign remain    = TRACK_C - nxt_pos;
    assign last_byte = (nxt_pos == TRACK_C);
    assign boundary  = (bps_c != '0) && (sec_bytes + 1'b1 == bps_c) && (remain >= bps_c);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TS_SEEK_INDEX;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TS_SEEK_INDEX: if (idx_ref) state_nx = TS_COUNT;
            TS_COUNT: begin
                if (idx_ref)                     state_nx = TS_COUNT;
                else if (byte_tick && last_byte) state_nx = TS_TRACK_END;
            end
            TS_TRACK_END:  if (idx_ref) state_nx = TS_COUNT;
            default:       state_nx = TS_SEEK_INDEX;
        endcase
    end

    // counters and event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_pos  <= '0;
            sec_bytes <= '0;
            bps_act   <= '0;
            sec_num   <= '0;
            idx_evt   <= 1'b0;
            sec_evt   <= 1'b0;
            byte_evt  <= 1'b0;
        end else begin
            idx_evt  <= idx_ref;
            byte_evt <= byte_tick;
            sec_evt  <= 1'b0;
            if (idx_ref) begin
                byte_pos  <= '0;
                sec_bytes <= '0;
                sec_num   <= '0;
                bps_act   <= cfg_bps;
                sec_evt   <= cfg_mark_at_index && (cfg_bps != '0);
            end else if (byte_tick && state == TS_COUNT) begin
                byte_pos <= nxt_pos;
                if (boundary) begin
                    sec_bytes <= '0;
                    sec_num   <= sec_num + 1'b1;
                    sec_evt   <= 1'b1;
                end else begin
                    sec_bytes <= sec_bytes + 1'b1;
                end
            end
        end
    end

    p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_ref |=> (sec_num == $past(sec_num)) || (sec_num == $past(sec_num) + 1'b1));
    p_idx_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_ref |=> (sec_num == '0) && (state == TS_COUNT));
    p_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bps_act == '0) |-> !sec_evt);
    p_end_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TS_COUNT) && !idx_ref |=> !sec_evt);
endmodule

// File: rtl/sector_mark_gen.sv
module sector_mark_gen
    import smg_pkg::*;
#(
    parameter int TRACK_BYTES = 12000,
    parameter int CLK_PER_US  = 50,
    parameter int BPS_W       = 12,
    parameter int SEC_W       = $clog2(TRACK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_ref,
    input  logic             byte_tick,
    input  logic [BPS_W-1:0] cfg_bps,
    input  logic             cfg_sel_byteclk,
    input  logic             cfg_mark_at_index,
    output logic             index_pulse,
    output logic             sector_pulse,
    output logic             byteclk_pulse,
    output logic             shared_out,
    output logic [SEC_W-1:0] sector_num
);
    localparam int MARK_W = width_clks(CLK_PER_US, 170);
    localparam int BYTE_W = width_clks(CLK_PER_US, 84);
    localparam int NSHAPE = 3;

    logic [NSHAPE-1:0] evt, pulse;

    smg_sector_counter #(
        .TRACK_BYTES(TRACK_BYTES),
        .BPS_W      (BPS_W),
        .SEC_W      (SEC_W)
    ) u_cnt (
        .clk              (clk),
        .rst_n            (rst_n),
        .idx_ref          (idx_ref),
        .byte_tick        (byte_tick),
        .cfg_bps          (cfg_bps),
        .cfg_mark_at_index(cfg_mark_at_index),
        .idx_evt          (evt[0]),
        .sec_evt          (evt[1]),
        .byte_evt         (evt[2]),
        .sec_num          (sector_num)
    );

    for (genvar g = 0; g < NSHAPE; g++) begin : g_shape
        localparam int W = (g == 2) ? BYTE_W : MARK_W;
        smg_pulse_shaper #(.W_CLKS(W)) u_shp (
            .clk  (clk),
            .rst_n(rst_n),
            .trig (evt[g]),
            .pulse(pulse[g])
        );
    end

    assign index_pulse   = pulse[0];
    assign sector_pulse  = pulse[1];
    assign byteclk_pulse = pulse[2];
    assign shared_out    = cfg_sel_byteclk ? byteclk_pulse : sector_pulse;
endmodule

// File: tb/tb_sector_mark_gen.sv
module tb_sector_mark_gen;
    localparam int TRACK = 100;
    localparam int CPU   = 2;
    localparam int SEC_W = $clog2(TRACK);
    localparam int MARK_W_EXP = 3;   // floor(2*17/10)
    localparam int BYTE_W_EXP = 1;   // max(1, floor(2*84/100))

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idx_ref = 1'b0, byte_tick = 1'b0;
    logic [11:0] cfg_bps = '0;
    logic cfg_sel_byteclk = 1'b0, cfg_mark_at_index = 1'b0;
    logic index_pulse, sector_pulse, byteclk_pulse, shared_out;
    logic [SEC_W-1:0] sector_num;

    int n_tests = 0, n_fail = 0;
    int sec_rises = 0, sh_rises = 0;
    logic sec_d = 1'b0, sh_d = 1'b0;

    always #10 clk = ~clk;

    sector_mark_gen #(.TRACK_BYTES(TRACK), .CLK_PER_US(CPU)) dut (
        .clk(clk), .rst_n(rst_n), .idx_ref(idx_ref), .byte_tick(byte_tick),
        .cfg_bps(cfg_bps), .cfg_sel_byteclk(cfg_sel_byteclk),
        .cfg_mark_at_index(cfg_mark_at_index), .index_pulse(index_pulse),
        .sector_pulse(sector_pulse), .byteclk_pulse(byteclk_pulse),
        .shared_out(shared_out), .sector_num(sector_num)
    );

    always @(negedge clk) begin
        if (sector_pulse && !sec_d) sec_rises++;
        if (shared_out && !sh_d) sh_rises++;
        sec_d <= sector_pulse;
        sh_d  <= shared_out;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_index();
        @(negedge clk) idx_ref = 1'b1;
        @(negedge clk) idx_ref = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic do_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) byte_tick = 1'b1;
            @(negedge clk) byte_tick = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic int exp_marks(input int bps);
        if (bps == 0 || bps > TRACK) return 0;
        return TRACK / bps - 1;
    endfunction

    // full revolution with a given setting
    task automatic t_revolution(input int bps, input logic at_idx);
        int s0;
        cfg_bps = 12'(bps);
        cfg_mark_at_index = at_idx;
        cfg_sel_byteclk = 1'b0;
        s0 = sec_rises;
        do_index();
        check("R4 sector_num after index", int'(sector_num), 0);
        check("R6 mark at index", sec_rises - s0, (at_idx && bps != 0) ? 1 : 0);
        do_bytes(TRACK);
        check("R5 marks per revolution", sec_rises - s0,
              exp_marks(bps) + ((at_idx && bps != 0) ? 1 : 0));
        check("R4 R5 final sector_num", int'(sector_num), exp_marks(bps));
    endtask

    task automatic t_reset();
        check("R1 index_pulse", int'(index_pulse), 0);
        check("R1 sector_pulse", int'(sector_pulse), 0);
        check("R1 byteclk_pulse", int'(byteclk_pulse), 0);
        check("R1 sector_num", int'(sector_num), 0);
    endtask

    task automatic t_no_index();
        int s0 = sec_rises;
        cfg_bps = 12'd5;
        do_bytes(30);
        check("R10 no marks before index", sec_rises - s0, 0);
        check("R10 sector_num before index", int'(sector_num), 0);
    endtask

    task automatic t_widths();
        int w_idx = 0, w_sec = 0, first = -1, w_b = 0;
        cfg_bps = 12'd10;
        cfg_mark_at_index = 1'b1;
        @(negedge clk) idx_ref = 1'b1;
        @(negedge clk) idx_ref = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (index_pulse) begin
                w_idx++;
                if (first < 0) first = k;
            end
            if (sector_pulse) w_sec++;
            @(negedge clk);
        end
        check("R2 index delay", first, 1);
        check("R2 index width", w_idx, MARK_W_EXP);
        check("R2 sector width", w_sec, MARK_W_EXP);
        @(negedge clk) byte_tick = 1'b1;
        @(negedge clk) byte_tick = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (byteclk_pulse) w_b++;
            @(negedge clk);
        end
        check("R3 byte clock width", w_b, BYTE_W_EXP);
    endtask

    task automatic t_track_end();
        int s0, sn;
        t_revolution(20, 1'b0);
        s0 = sec_rises;
        sn = int'(sector_num);
        do_bytes(25);
        check("R10 no marks after track end", sec_rises - s0, 0);
        check("R10 sector_num held", int'(sector_num), sn);
    endtask

    task automatic t_deferred();
        int s0;
        cfg_bps = 12'd30;
        cfg_mark_at_index = 1'b0;
        s0 = sec_rises;
        do_index();
        do_bytes(10);
        cfg_bps = 12'd25;
        do_bytes(TRACK - 10);
        check("R8 old setting kept", sec_rises - s0, 2);
        s0 = sec_rises;
        do_index();
        do_bytes(TRACK);
        check("R8 new setting at index", sec_rises - s0, 3);
    endtask

    task automatic t_shared();
        int h0;
        cfg_bps = 12'd25;
        cfg_mark_at_index = 1'b0;
        cfg_sel_byteclk = 1'b1;
        do_index();
        h0 = sh_rises;
        do_bytes(40);
        check("R7 shared carries byte clocks", sh_rises - h0, 40);
        cfg_sel_byteclk = 1'b0;
        repeat (4) @(negedge clk);
        h0 = sh_rises;
        do_bytes(60);
        check("R7 shared carries sector marks", sh_rises - h0, 2);
    endtask

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_no_index();
        t_widths();
        t_revolution(25, 1'b0);   // exact division
        t_revolution(30, 1'b0);   // remainder folded in
        t_revolution(7, 1'b1);    // short sectors, mark at index
        t_revolution(200, 1'b1);  // longer than track
        t_revolution(0, 1'b1);    // R9 zero disables all marks
        t_track_end();
        t_deferred();
        t_shared();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule